// File: doc/BRIEF.md
# Programmable External Reset Pulse Generator

This block stretches a one-cycle reset request from a watchdog timer into a reset pulse on an external pin. The pulse length is programmable. One 32-bit configuration word holds a pulse-length field, a polarity bit and a drive-style bit. The pulse length is counted in strobes of an external microsecond tick. The output is either driven push-pull or modelled as open-drain through a separate output-enable signal.

The polarity and drive-style bits are protected against accidental writes. Each bit only changes when the top byte of a write carries one of four fixed key values. Every write updates the length field, whatever its top byte holds. A parameter shrinks the length field from 20 bits to 8 bits for a narrow build. The pin goes active on the first tick after a request and stays active for the programmed value plus one tick.

Top module: `rstpulse_gen`

## Requirements
- R1: After reset the length field is 0xFF and the polarity and drive-style bits are 0. In this state the read word is 0x000000FF, the pin sits at its inactive level (high) and the output enable is 0.
- R2: The read word carries the polarity bit at bit 31 (1 = active-high) and the drive-style bit at bit 30 (1 = push-pull). The length field occupies the low bits and all other bits read 0.
- R3: Every write loads the length field from the low bits of the write data, whatever the top byte holds.
- R4: A write whose top byte is 0xA5 sets the polarity bit and one with 0x5A clears it. A top byte of 0xA8 sets the drive-style bit and one of 0x8A clears it.
- R5: A write with any other top-byte value leaves both the polarity bit and the drive-style bit unchanged.
- R6: A request accepted while idle makes the pin active at the next tick strobe. The pin stays active for exactly length+1 tick strobes. The length is captured at the start strobe, so a write in that same cycle affects only later pulses.
- R7: When the pin is active it shows the polarity bit, and when inactive it shows the inverse. In push-pull mode the output enable is always 1. In open-drain mode the output enable is 1 only while the pin is active.
- R8: A request that arrives while a pulse is active, or while one is already pending, is ignored. No second pulse follows and the current pulse is not lengthened.
- R9: The pulse state changes only in cycles that carry a tick strobe. A request between strobes leaves the pin idle until the next strobe.
- R10: With the narrow parameter setting, the length field is 8 bits wide (bits 7:0) and bits 29:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current configuration word |
| tick | input | 1 | One-cycle microsecond strobe |
| trig | input | 1 | Reset request from the watchdog |
| pin_o | output | 1 | Reset pin level |
| pin_oe | output | 1 | Reset pin output enable |

## Verification
Two functions can land in the same clock cycle: a configuration write and the tick strobe that starts a pulse. The bench provokes this by making a request between ticks. It then issues a write with a larger length in the same cycle as the next tick. The pulse must last the old length plus one, while the read word already shows the new length. A second collision puts a request inside a running pulse. It is judged by a pulse length that does not change and by the pin staying idle for several ticks after the pulse ends.

// File: rtl/rstpulse_pkg.sv
package rstpulse_pkg;

  localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PP       = 8'hA8;
  localparam logic [7:0] KEY_OD       = 8'h8A;

  typedef struct packed {
    logic pol_we;
    logic pol_val;
    logic pp_we;
    logic pp_val;
  } key_dec_t;

  function automatic int unsigned field_bits(input bit wide);
    return wide ? 20 : 8;
  endfunction

  function automatic key_dec_t decode_key(input logic [7:0] top);
    key_dec_t d;
    d = '0;
    unique case (top)
      KEY_POL_HIGH: begin d.pol_we = 1'b1; d.pol_val = 1'b1; end
      KEY_POL_LOW:  begin d.pol_we = 1'b1; d.pol_val = 1'b0; end
      KEY_PP:       begin d.pp_we  = 1'b1; d.pp_val  = 1'b1; end
      KEY_OD:       begin d.pp_we  = 1'b1; d.pp_val  = 1'b0; end
      default:      d = '0;
    endcase
    return d;
  endfunction

  function automatic logic pin_level(input logic active, input logic pol);
    return active ? pol : ~pol;
  endfunction

  function automatic logic drive_enable(input logic active, input logic pp);
    return pp | active;
  endfunction

endpackage

// File: rtl/rstpulse_cfg.sv
module rstpulse_cfg #(
  parameter int unsigned W         = 20,
  parameter int unsigned RST_WIDTH = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [W-1:0]  width_q,
  output logic          pol_q,
  output logic          pp_q,
  output logic [31:0]   rd_data
);
  import rstpulse_pkg::*;

  localparam logic [W-1:0] WIDTH_INIT = W'(RST_WIDTH);
  localparam int unsigned  PAD_W      = 30 - W;

  key_dec_t dec;
  assign dec = decode_key(wr_data[31:24]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= WIDTH_INIT;
      pol_q   <= 1'b0;
      pp_q    <= 1'b0;
    end else if (wr_en) begin
      width_q <= wr_data[W-1:0];
      if (dec.pol_we) pol_q <= dec.pol_val;
      if (dec.pp_we)  pp_q  <= dec.pp_val;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {pol_q, pp_q, {PAD_W{1'b0}}, width_q};
    end else begin : g_full
      assign rd_data = {pol_q, pp_q, width_q};
    end
  endgenerate

endmodule

// File: rtl/rstpulse_seq.sv
module rstpulse_seq #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         trig,
  input  logic [W-1:0] width_q,
  output logic         active,
  output logic         start_evt,
  output logic         end_evt
);
  logic         pend_q;
  logic         active_q;
  logic [W-1:0] cnt_q;

  assign start_evt = tick & ~active_q & (pend_q | trig);
  assign end_evt   = tick & active_q & (cnt_q == '0);
  assign active    = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (start_evt) begin
        active_q <= 1'b1;
        cnt_q    <= width_q;
      end else if (end_evt) begin
        active_q <= 1'b0;
      end else if (tick && active_q) begin
        cnt_q    <= cnt_q - 1'b1;
      end

      if (start_evt)                pend_q <= 1'b0;
      else if (trig && !active_q)   pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rstpulse_drv.sv
module rstpulse_drv (
  input  logic active,
  input  logic pol,
  input  logic pp,
  output logic pin_o,
  output logic pin_oe
);
  import rstpulse_pkg::*;

  assign pin_o  = pin_level(active, pol);
  assign pin_oe = drive_enable(active, pp);

endmodule

// File: rtl/rstpulse_gen.sv
module rstpulse_gen #(
  parameter bit          WIDE      = 1'b1,
  parameter int unsigned RST_WIDTH = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        tick,
  input  logic        trig,
  output logic        pin_o,
  output logic        pin_oe
);
  import rstpulse_pkg::*;

  localparam int unsigned FIELD_W = field_bits(WIDE);

  logic [FIELD_W-1:0] width_w;
  logic               pol_w;
  logic               pp_w;
  logic               active_w;
  logic               start_w;
  logic               end_w;

  rstpulse_cfg #(.W(FIELD_W), .RST_WIDTH(RST_WIDTH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .width_q (width_w),
    .pol_q   (pol_w),
    .pp_q    (pp_w),
    .rd_data (rd_data)
  );

  rstpulse_seq #(.W(FIELD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .trig      (trig),
    .width_q   (width_w),
    .active    (active_w),
    .start_evt (start_w),
    .end_evt   (end_w)
  );

  rstpulse_drv u_drv (
    .active (active_w),
    .pol    (pol_w),
    .pp     (pp_w),
    .pin_o  (pin_o),
    .pin_oe (pin_oe)
  );

endmodule

// File: rtl/rstpulse_gen_chk.sv
module rstpulse_gen_chk #(
  parameter bit WIDE = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        tick,
  input logic        pin_o,
  input logic        pin_oe,
  input logic        active,
  input logic        start_evt,
  input logic        end_evt
);
  localparam int unsigned W = WIDE ? 20 : 8;

  logic key_any;
  assign key_any = (wr_data[31:24] == 8'hA5) || (wr_data[31:24] == 8'h5A) ||
                   (wr_data[31:24] == 8'hA8) || (wr_data[31:24] == 8'h8A);

  AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[W-1:0] == $past(wr_data[W-1:0])); // R3
  AST_POL_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[31:24] == 8'hA5 |=> rd_data[31]); // R4
  AST_PP_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[31:24] == 8'h8A |=> !rd_data[30]); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !key_any |=> rd_data[31:30] == $past(rd_data[31:30])); // R5
  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> active); // R6
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !active); // R6
  AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> pin_o == rd_data[31]); // R7
  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[30] && !active |-> !pin_oe); // R7
  AST_PP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[30] |-> pin_oe); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start_evt); // R8
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(active)); // R9

endmodule

bind rstpulse_gen rstpulse_gen_chk #(.WIDE(WIDE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .tick      (tick),
  .pin_o     (pin_o),
  .pin_oe    (pin_oe),
  .active    (active_w),
  .start_evt (start_w),
  .end_evt   (end_w)
);

// File: tb/rstpulse_gen_tb.sv
module rstpulse_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {write data, expected wide read word}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h00000010, 32'h00000010},
    {32'hA5000020, 32'h80000020},
    {32'hA8000030, 32'hC0000030},
    {32'h12000040, 32'hC0000040},
    {32'h5A000005, 32'h40000005},
    {32'h8A0FFFFF, 32'h000FFFFF},
    {32'hA5F00003, 32'h80000003},
    {32'hFFFFFFFF, 32'h800FFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic tick = 1'b0;
  logic trig = 1'b0;
  logic [31:0] rd_data, rd_nr;
  logic pin_o, pin_oe, pin_nr, oe_nr;

  int checks = 0;
  int fails = 0;
  logic pol_exp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstpulse_gen #(.WIDE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .trig(trig), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  rstpulse_gen #(.WIDE(1'b0)) u_dut_nr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_nr), .tick(tick), .trig(trig), .pin_o(pin_nr), .pin_oe(oe_nr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  // counts tick strobes after which the pin is active; stops at the first idle one
  task automatic measure(input int trig_at, output int n, output logic oe_ok);
    n = 0;
    oe_ok = 1'b1;
    for (int i = 0; i < 400; i++) begin
      do_tick();
      if (pin_o !== pol_exp) break;
      n++;
      if (pin_oe !== 1'b1) oe_ok = 1'b0;
      if (n == trig_at) pulse_trig();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 read word", rd_data, 32'h000000FF);
    check("R1 idle pin", {31'b0, pin_o}, 32'd1);
    check("R1 idle oe", {31'b0, pin_oe}, 32'd0);
    check("R10 narrow reset", rd_nr, 32'h000000FF);

    // R2 R3 R4 R5 R10 table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] d, e;
      d = VEC[i][63:32];
      e = VEC[i][31:0];
      write_word(d);
      check("R2/R3/R4/R5 read word", rd_data, e);
      check("R10 narrow read word", rd_nr, {e[31:30], 22'b0, d[7:0]});
    end
    pol_exp = 1'b1;

    // R6 R7 push-pull active-high, length 3
    write_word(32'hA8000003);
    check("R7 pp idle oe", {31'b0, pin_oe}, 32'd1);
    check("R7 active-high idle level", {31'b0, pin_o}, 32'd0);
    pulse_trig();
    measure(0, n, ok);
    check("R6 pulse length 3+1", n, 32'd4);
    check("R7 pp oe during pulse", {31'b0, ok}, 32'd1);

    // R7 open-drain active-low, length 0
    write_word(32'h5A000000);
    write_word(32'h8A000000);
    pol_exp = 1'b0;
    check("R4 config cleared", rd_data, 32'h00000000);
    check("R7 od idle release", {31'b0, pin_oe}, 32'd0);
    pulse_trig();
    measure(0, n, ok);
    check("R6 pulse length 0+1", n, 32'd1);
    check("R7 od oe while active", {31'b0, ok}, 32'd1);
    check("R7 od release after pulse", {31'b0, pin_oe}, 32'd0);

    // R9 request between ticks waits for a strobe
    write_word(32'h00000002);
    pulse_trig();
    repeat (3) @(negedge clk);
    check("R9 idle before tick", {31'b0, pin_o}, 32'd1);
    measure(0, n, ok);
    check("R9 pulse length after wait", n, 32'd3);

    // R8 request during a pulse is ignored
    write_word(32'h00000004);
    pulse_trig();
    measure(2, n, ok);
    check("R8 length unchanged", n, 32'd5);
    n = 0;
    for (int i = 0; i < 3; i++) begin
      do_tick();
      if (pin_o === pol_exp) n++;
    end
    check("R8 no second pulse", n, 32'd0);

    // R6 write colliding with the start strobe
    write_word(32'h00000002);
    pulse_trig();
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = 32'h00000005;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R6 started on collision tick", {31'b0, pin_o}, 32'd0);
    check("R3 write taken on collision", rd_data, 32'h00000005);
    n = 1;
    for (int i = 0; i < 20; i++) begin
      do_tick();
      if (pin_o !== pol_exp) break;
      n++;
    end
    check("R6 old length captured", n, 32'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule